// File: doc/BRIEF.md
# Two-Pass 8x8 Transform Memory Sequencer

This block drives a separable 8x8 transform (forward or inverse) in place on a block of 16-bit samples held in a shared 32-bit data memory. A host gives it a base address and a direction bit and pulses start. The block then makes sixteen 1-D passes. The first eight work on the rows and the next eight on the columns. For each 1-D pass it reads one vector into eight 16-bit holding registers. It runs a four-step 1-D kernel on them and writes the vector back to the locations it came from. When the last column is written it raises a one-cycle completion pulse and returns to idle.

The memory stores the 64 samples two per 32-bit word. Element (row r, column c) lives in word (r/2)*8 + c. Even rows use the lower half and odd rows the upper half. With this layout a row pass pulls one useful sample per access (eight accesses per vector), while a column pass pulls two samples per access (four accesses per vector). Writes use the same access pattern as the reads of that pass, with half-word write enables. The 1-D arithmetic is a fixed-latency stub: four butterfly-and-rotate steps, each taking a parameterised number of cycles. The memory is expected to answer a read on the cycle after the request.

Top module: `xform2d_ctrl`

## Requirements
- R1: After reset, fin_o, mem_rd_o and mem_wr_o are low and the block waits in idle.
- R2: start_i, inv_i and base_addr_i are sampled only in idle, in the cycle start_i is high. A start pulse, a direction change or a base change during a run alters neither the result nor the run length.
- R3: Row pass: the rows r = 0..7 are taken in order. Each takes 8 reads, where beat c reads byte address base + 4*((r/2)*8 + c). Bits 15:0 of that word hold element (r,c) for even r, and bits 31:16 hold it for odd r.
- R4: Column pass: the columns c = 0..7 are taken in order after all rows. Each takes 4 reads, where beat k reads base + 4*(k*8 + c), with row 2k in bits 15:0 and row 2k+1 in bits 31:16. A run makes 96 reads in total.
- R5: Each vector is written back to the same address sequence it was read from. mem_hwe_o bit 0 enables bits 15:0 and bit 1 enables bits 31:16. Row writes use 2'b01 for even r and 2'b10 for odd r, and column writes use 2'b11. A run makes 96 writes.
- R6: Each vector takes (beats+1) read cycles, then 4*STEP_CYC kernel cycles, then one write per beat. With start sampled in cycle 0, fin_o is high in cycle 8*(17+4*STEP_CYC) + 8*(9+4*STEP_CYC) + 1.
- R7: fin_o is high for exactly one cycle. There is no memory access in that cycle or in the idle cycle after it.
- R8: Forward direction (inv_i=0): each of the four kernel steps forms, for i<4, t[i]=(v[i]+v[7-i])>>>1 and t[7-i]=(v[i]-v[7-i])>>>1. Sums wrap to 16 bits before the arithmetic shift. The step output is then out[i]=t[(i+1) mod 8]. All rows are transformed before any column.
- R9: Inverse direction (inv_i=1): the same steps as R8, with no shift.
- R10: mem_rd_o and mem_wr_o are never high together, and mem_hwe_o is zero whenever mem_wr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in idle |
| inv_i | input | 1 | Direction: 0 forward, 1 inverse |
| base_addr_i | input | 32 | Byte address of the block |
| mem_addr_o | output | 32 | Byte address of the current access |
| mem_rd_o | output | 1 | Read request, data expected one cycle later |
| mem_wr_o | output | 1 | Write request |
| mem_hwe_o | output | 2 | Half-word write enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| fin_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the change of access pattern between the passes. A design that kept the row packing for columns would make 128 reads instead of 96 and fetch the wrong words. A design that used the wrong half for odd rows would corrupt its neighbour sample, and that shows up in the final memory image. A start pulse with a flipped direction is injected in the middle of a run; a block that sampled start or mode outside idle would restart or mix the directions. Full-scale alternating 0x7FFF/0x8000 blocks exercise the 16-bit wrap ahead of the halving shift, and the measured start-to-fin distance catches any extra or missing capture or kernel cycle.

// File: rtl/xf_pkg.sv
package xf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_KERN  = 3'd2,
      ST_WRITE = 3'd3,
      ST_FIN   = 3'd4
   } seq_st_e;

   typedef enum logic {
      PASS_ROW = 1'b0,
      PASS_COL = 1'b1
   } pass_e;
endpackage

// File: rtl/xf_addr_gen.sv
// Maps (pass, vector index, beat) onto a memory address.
module xf_addr_gen
   import xf_pkg::*;
#(
   parameter int N         = 8,
   parameter int AW        = 32,
   parameter int MW        = 32,
   parameter bit BYTE_ADDR = 1'b1,
   localparam int VW = $clog2(N),
   localparam int BW = $clog2(N) + 1
) (
   input  logic [AW-1:0] base_i,
   input  pass_e         pass_i,
   input  logic [VW-1:0] vidx_i,
   input  logic [BW-1:0] beat_i,
   output logic [AW-1:0] addr_o
);
   localparam int SH = $clog2(MW / 8);

   int          w_row;
   int          w_col;
   logic [AW-1:0] word;

   always_comb begin
      w_row = (int'(vidx_i) / 2) * N + int'(beat_i);
      w_col = int'(beat_i) * N + int'(vidx_i);
      word  = (pass_i == PASS_ROW) ? AW'(w_row) : AW'(w_col);
   end

   generate
      if (BYTE_ADDR) begin : g_byte
         assign addr_o = base_i + (word << SH);
      end else begin : g_word
         assign addr_o = base_i + word;
      end
   endgenerate
endmodule

// File: rtl/xf_vec_regs.sv
// Holding registers for one vector, with the pass-dependent packing for reads and writes.
module xf_vec_regs
   import xf_pkg::*;
#(
   parameter int N  = 8,
   parameter int EW = 16,
   parameter int MW = 32,
   localparam int BW = $clog2(N) + 1,
   localparam int HW = MW / EW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  pass_e                 pass_i,
   input  logic                  odd_i,
   input  logic                  cap_i,
   input  logic [BW-1:0]         cap_beat_i,
   input  logic [MW-1:0]         rdata_i,
   input  logic                  kload_i,
   input  logic [N-1:0][EW-1:0]  kvec_i,
   input  logic [BW-1:0]         wr_beat_i,
   output logic [N-1:0][EW-1:0]  vec_o,
   output logic [MW-1:0]         wdata_o,
   output logic [HW-1:0]         hwe_o
);
   logic [EW-1:0] lo_half;
   logic [EW-1:0] hi_half;
   logic [EW-1:0] row_pick;

   assign lo_half  = rdata_i[EW-1:0];
   assign hi_half  = rdata_i[MW-1:MW-EW];
   assign row_pick = odd_i ? hi_half : lo_half;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_elem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_o[gi] <= '0;
            end else if (kload_i) begin
               vec_o[gi] <= kvec_i[gi];
            end else if (cap_i) begin
               if (pass_i == PASS_ROW) begin
                  if (int'(cap_beat_i) == gi) vec_o[gi] <= row_pick;
               end else begin
                  if (int'(cap_beat_i) == gi / 2) vec_o[gi] <= (gi % 2 == 1) ? hi_half : lo_half;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      wdata_o = '0;
      for (int i = 0; i < N; i++) begin
         if (pass_i == PASS_ROW) begin
            if (int'(wr_beat_i) == i) wdata_o = {vec_o[i], vec_o[i]};
         end else if (int'(wr_beat_i) == i / 2) begin
            if (i % 2 == 0) wdata_o[EW-1:0]  = vec_o[i];
            else            wdata_o[MW-1:EW] = vec_o[i];
         end
      end
   end

   always_comb begin
      if (pass_i == PASS_COL) hwe_o = '1;
      else                    hwe_o = odd_i ? HW'(2) : HW'(1);
   end
endmodule

// File: rtl/xf_kernel_stub.sv
// Fixed-latency 1-D kernel stand-in: N_STEPS butterfly/rotate steps of STEP_CYC cycles each.
module xf_kernel_stub #(
   parameter int N        = 8,
   parameter int EW       = 16,
   parameter int N_STEPS  = 4,
   parameter int STEP_CYC = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_i,
   input  logic                 inv_i,
   input  logic [N-1:0][EW-1:0] vec_i,
   output logic                 upd_o,
   output logic                 done_o,
   output logic [N-1:0][EW-1:0] vec_o
);
   localparam int HALF = N / 2;
   localparam int SW   = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

   logic [N-1:0][EW-1:0] bfly;
   logic                 busy_q;
   logic [SW-1:0]        step_q;
   logic                 tick;

   genvar gi;
   generate
      for (gi = 0; gi < HALF; gi++) begin : g_lane
         logic [EW-1:0] sum_w;
         logic [EW-1:0] dif_w;
         assign sum_w = vec_i[gi] + vec_i[N-1-gi];
         assign dif_w = vec_i[gi] - vec_i[N-1-gi];
         assign bfly[gi]      = inv_i ? sum_w : {sum_w[EW-1], sum_w[EW-1:1]};
         assign bfly[N-1-gi]  = inv_i ? dif_w : {dif_w[EW-1], dif_w[EW-1:1]};
      end
      for (gi = 0; gi < N; gi++) begin : g_rot
         assign vec_o[gi] = bfly[(gi + 1) % N];
      end

      if (STEP_CYC == 1) begin : g_fast
         assign tick = 1'b1;
      end else begin : g_slow
         localparam int CW = $clog2(STEP_CYC);
         logic [CW-1:0] cnt_q;
         assign tick = (cnt_q == CW'(STEP_CYC - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (!busy_q || tick) cnt_q <= '0;
            else                      cnt_q <= cnt_q + CW'(1);
         end
      end
   endgenerate

   assign upd_o  = busy_q && tick;
   assign done_o = upd_o && (step_q == SW'(N_STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else if (go_i) begin
         busy_q <= 1'b1;
         step_q <= '0;
      end else if (upd_o) begin
         if (done_o) busy_q <= 1'b0;
         else        step_q <= step_q + SW'(1);
      end
   end
endmodule

// File: rtl/xf_seq.sv
// Two-level sequencer: N vectors per pass, row pass then column pass; read/kernel/write per vector.
module xf_seq
   import xf_pkg::*;
#(
   parameter int N = 8,
   localparam int VW = $clog2(N),
   localparam int BW = $clog2(N) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          kdone_i,
   output logic          latch_o,
   output logic          rd_o,
   output logic          wr_o,
   output logic          cap_o,
   output logic [BW-1:0] cap_beat_o,
   output logic          kgo_o,
   output logic          fin_o,
   output pass_e         pass_o,
   output logic [VW-1:0] vidx_o,
   output logic [BW-1:0] beat_o
);
   seq_st_e       st_q;
   pass_e         pass_q;
   logic [VW-1:0] vidx_q;
   logic [BW-1:0] beat_q;
   logic [BW-1:0] nbeat;

   assign nbeat = (pass_q == PASS_ROW) ? BW'(N) : BW'(N / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pass_q <= PASS_ROW;
         vidx_q <= '0;
         beat_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_READ;
                  pass_q <= PASS_ROW;
                  vidx_q <= '0;
                  beat_q <= '0;
               end
            end
            ST_READ: begin
               if (beat_q == nbeat) begin
                  st_q   <= ST_KERN;
                  beat_q <= '0;
               end else begin
                  beat_q <= beat_q + BW'(1);
               end
            end
            ST_KERN: begin
               if (kdone_i) st_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (beat_q == nbeat - BW'(1)) begin
                  beat_q <= '0;
                  if (vidx_q == VW'(N - 1)) begin
                     vidx_q <= '0;
                     if (pass_q == PASS_COL) begin
                        st_q <= ST_FIN;
                     end else begin
                        pass_q <= PASS_COL;
                        st_q   <= ST_READ;
                     end
                  end else begin
                     vidx_q <= vidx_q + VW'(1);
                     st_q   <= ST_READ;
                  end
               end else begin
                  beat_q <= beat_q + BW'(1);
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign latch_o    = (st_q == ST_IDLE) && start_i;
   assign rd_o       = (st_q == ST_READ) && (beat_q != nbeat);
   assign cap_o      = (st_q == ST_READ) && (beat_q != '0);
   assign cap_beat_o = beat_q - BW'(1);
   assign kgo_o      = (st_q == ST_READ) && (beat_q == nbeat);
   assign wr_o       = (st_q == ST_WRITE);
   assign fin_o      = (st_q == ST_FIN);
   assign pass_o     = pass_q;
   assign vidx_o     = vidx_q;
   assign beat_o     = beat_q;
endmodule

// File: rtl/xform2d_ctrl.sv
module xform2d_ctrl
   import xf_pkg::*;
#(
   parameter int N         = 8,
   parameter int EW        = 16,
   parameter int MW        = 32,
   parameter int AW        = 32,
   parameter int N_STEPS   = 4,
   parameter int STEP_CYC  = 2,
   parameter bit BYTE_ADDR = 1'b1,
   localparam int HW = MW / EW,
   localparam int VW = $clog2(N),
   localparam int BW = $clog2(N) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          inv_i,
   input  logic [AW-1:0] base_addr_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_rd_o,
   output logic          mem_wr_o,
   output logic [HW-1:0] mem_hwe_o,
   output logic [MW-1:0] mem_wdata_o,
   input  logic [MW-1:0] mem_rdata_i,
   output logic          fin_o
);
   initial begin
      assert (MW == 2 * EW) else $fatal(1, "memory word must hold exactly two samples");
      assert (N >= 2 && N % 2 == 0) else $fatal(1, "vector length must be even");
      assert (N_STEPS >= 1 && STEP_CYC >= 1) else $fatal(1, "kernel timing must be positive");
   end

   logic          latch;
   logic          rd;
   logic          wr;
   logic          cap;
   logic [BW-1:0] cap_beat;
   logic          kgo;
   logic          kupd;
   logic          kdone;
   pass_e         pass;
   logic [VW-1:0] vidx;
   logic [BW-1:0] beat;
   logic [AW-1:0] base_q;
   logic          inv_q;
   logic [N-1:0][EW-1:0] vec;
   logic [N-1:0][EW-1:0] kvec;
   logic [HW-1:0] hwe_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         inv_q  <= 1'b0;
      end else if (latch) begin
         base_q <= base_addr_i;
         inv_q  <= inv_i;
      end
   end

   xf_seq #(.N(N)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .kdone_i    (kdone),
      .latch_o    (latch),
      .rd_o       (rd),
      .wr_o       (wr),
      .cap_o      (cap),
      .cap_beat_o (cap_beat),
      .kgo_o      (kgo),
      .fin_o      (fin_o),
      .pass_o     (pass),
      .vidx_o     (vidx),
      .beat_o     (beat)
   );

   xf_addr_gen #(.N(N), .AW(AW), .MW(MW), .BYTE_ADDR(BYTE_ADDR)) u_addr (
      .base_i (base_q),
      .pass_i (pass),
      .vidx_i (vidx),
      .beat_i (beat),
      .addr_o (mem_addr_o)
   );

   xf_vec_regs #(.N(N), .EW(EW), .MW(MW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .pass_i     (pass),
      .odd_i      (vidx[0]),
      .cap_i      (cap),
      .cap_beat_i (cap_beat),
      .rdata_i    (mem_rdata_i),
      .kload_i    (kupd),
      .kvec_i     (kvec),
      .wr_beat_i  (beat),
      .vec_o      (vec),
      .wdata_o    (mem_wdata_o),
      .hwe_o      (hwe_raw)
   );

   xf_kernel_stub #(.N(N), .EW(EW), .N_STEPS(N_STEPS), .STEP_CYC(STEP_CYC)) u_kern (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (kgo),
      .inv_i  (inv_q),
      .vec_i  (vec),
      .upd_o  (kupd),
      .done_o (kdone),
      .vec_o  (kvec)
   );

   assign mem_rd_o  = rd;
   assign mem_wr_o  = wr;
   assign mem_hwe_o = wr ? hwe_raw : '0;
endmodule

// File: rtl/xf_chk.sv
module xf_chk #(
   parameter int HW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd_o,
   input logic          mem_wr_o,
   input logic [HW-1:0] mem_hwe_o,
   input logic          fin_o
);
   assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   assert_hwe_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_o |-> (mem_hwe_o == '0));

   assert_hwe_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_hwe_o != '0));

   assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !fin_o);

   assert_fin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> (!mem_rd_o && !mem_wr_o));

   assert_fin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> (!mem_rd_o && !mem_wr_o));
endmodule

bind xform2d_ctrl xf_chk #(.HW(MW / EW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd_o  (mem_rd_o),
   .mem_wr_o  (mem_wr_o),
   .mem_hwe_o (mem_hwe_o),
   .fin_o     (fin_o)
);

// File: tb/sim_xform2d_ctrl.sv
`timescale 1ns/100ps
module sim_xform2d_ctrl;
   localparam int STEPC = 2;
   localparam int EXP_CYC = 8 * (8 + 1 + 4 * STEPC + 8) + 8 * (4 + 1 + 4 * STEPC + 4) + 1;

   typedef logic [15:0] vec_t [8];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        inv_i = 1'b0;
   logic [31:0] base_addr = '0;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [1:0]  mem_hwe;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        fin;

   logic [31:0] ram [64];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit mon_en = 1'b0;
   int mon_base = 0;
   int rd_n, wr_n, rd_row_err, rd_col_err, wr_err;
   int first_act, first_exp;

   always #2.5 clk = ~clk;

   xform2d_ctrl #(.STEP_CYC(STEPC)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .inv_i       (inv_i),
      .base_addr_i (base_addr),
      .mem_addr_o  (mem_addr),
      .mem_rd_o    (mem_rd),
      .mem_wr_o    (mem_wr),
      .mem_hwe_o   (mem_hwe),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (mem_rdata),
      .fin_o       (fin)
   );

   // synchronous RAM, one-cycle read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= ram[mem_addr[7:2]];
      if (mem_wr) begin
         if (mem_hwe[0]) ram[mem_addr[7:2]][15:0]  <= mem_wdata[15:0];
         if (mem_hwe[1]) ram[mem_addr[7:2]][31:16] <= mem_wdata[31:16];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // n-th access of a run -> expected word offset and half enables (R3, R4, R5)
   task automatic exp_loc(input int n, output int word, output logic [1:0] hwe);
      int r, c, k, j;
      if (n < 64) begin
         r = n / 8; k = n % 8;
         word = (r / 2) * 8 + k;
         hwe = (r % 2 == 1) ? 2'b10 : 2'b01;
      end else begin
         j = n - 64; c = j / 4; k = j % 4;
         word = k * 8 + c;
         hwe = 2'b11;
      end
   endtask

   function automatic vec_t kstep(vec_t v, bit inv);
      vec_t t, o;
      logic signed [15:0] s, d;
      for (int i = 0; i < 4; i++) begin
         s = v[i] + v[7-i];
         d = v[i] - v[7-i];
         if (!inv) begin s = s >>> 1; d = d >>> 1; end
         t[i] = s; t[7-i] = d;
      end
      for (int i = 0; i < 8; i++) o[i] = t[(i + 1) % 8];
      return o;
   endfunction

   function automatic vec_t kern4(vec_t v, bit inv);
      vec_t o = v;
      for (int s = 0; s < 4; s++) o = kstep(o, inv);
      return o;
   endfunction

   function automatic logic [15:0] rd_elem(int base_w, int r, int c);
      logic [31:0] w = ram[base_w + (r / 2) * 8 + c];
      return (r % 2 == 1) ? w[31:16] : w[15:0];
   endfunction

   always @(negedge clk) begin
      int w;
      logic [1:0] h;
      if (mon_en) begin
         if (mem_rd) begin
            exp_loc(rd_n, w, h);
            if (mem_addr !== 32'(mon_base * 4 + w * 4)) begin
               if (rd_n < 64) rd_row_err++; else rd_col_err++;
               first_act = int'(mem_addr); first_exp = mon_base * 4 + w * 4;
            end
            rd_n++;
         end
         if (mem_wr) begin
            exp_loc(wr_n, w, h);
            if (mem_addr !== 32'(mon_base * 4 + w * 4) || mem_hwe !== h) wr_err++;
            wr_n++;
         end
      end
   end

   task automatic fill(input int base_w, input int kind);
      logic [15:0] v;
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) begin
            case (kind)
               0:       v = 16'(r * 8 + c * 3 - 20);
               1:       v = ((r + c) % 2 == 1) ? 16'h7fff : 16'h8000;
               default: v = 16'($urandom);
            endcase
            if (r % 2 == 1) ram[base_w + (r / 2) * 8 + c][31:16] = v;
            else            ram[base_w + (r / 2) * 8 + c][15:0]  = v;
         end
   endtask

   task automatic run_block(input int base_w, input bit inv, input bit poke, input string tag);
      vec_t m [8];
      vec_t v;
      int n, mism;
      logic [15:0] got, fexp, fgot;
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) m[r][c] = rd_elem(base_w, r, c);
      for (int r = 0; r < 8; r++) m[r] = kern4(m[r], inv);
      for (int c = 0; c < 8; c++) begin
         for (int r = 0; r < 8; r++) v[r] = m[r][c];
         v = kern4(v, inv);
         for (int r = 0; r < 8; r++) m[r][c] = v[r];
      end
      rd_n = 0; wr_n = 0; rd_row_err = 0; rd_col_err = 0; wr_err = 0;
      first_act = 0; first_exp = 0;
      mon_base = base_w; mon_en = 1'b1;
      @(negedge clk);
      base_addr = 32'(base_w * 4); inv_i = inv; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; base_addr = 32'h0000_0040; inv_i = ~inv; // R2: changes after sampling
      n = 1;
      while (!fin && n < 5000) begin
         if (poke && n == 150) start_i = 1'b1;  // R2: start during a run
         if (poke && n == 151) start_i = 1'b0;
         @(negedge clk);
         n++;
      end
      chk(n == EXP_CYC, "R6", {tag, " cycles from start to fin"}, n, EXP_CYC);
      @(negedge clk);
      chk(!fin && !mem_rd && !mem_wr, "R7", {tag, " fin pulse width / idle after"},
          {fin, mem_rd, mem_wr}, 0);
      mon_en = 1'b0;
      chk(rd_n == 96, "R4", {tag, " read count"}, rd_n, 96);
      chk(rd_row_err == 0, "R3", {tag, " row read address"}, first_act, first_exp);
      chk(rd_col_err == 0, "R4", {tag, " column read address"}, first_act, first_exp);
      chk(wr_n == 96 && wr_err == 0, "R5", {tag, " write addresses and enables"}, wr_err, 0);
      mism = 0; fexp = '0; fgot = '0;
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) begin
            got = rd_elem(base_w, r, c);
            if (got !== m[r][c]) begin
               if (mism == 0) begin fgot = got; fexp = m[r][c]; end
               mism++;
            end
         end
      if (inv) chk(mism == 0, "R9", {tag, " inverse result block"}, fgot, fexp);
      else     chk(mism == 0, "R8", {tag, " forward result block"}, fgot, fexp);
      if (poke) chk(mism == 0 && n == EXP_CYC, "R2", {tag, " start ignored while busy"}, n, EXP_CYC);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) ram[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!fin && !mem_rd && !mem_wr, "R1", "outputs after reset", {fin, mem_rd, mem_wr}, 0);
      repeat (4) @(negedge clk);
      chk(!fin && !mem_rd && !mem_wr, "R1", "stays idle without start", {fin, mem_rd, mem_wr}, 0);

      fill(0, 0);   run_block(0, 1'b0, 1'b0, "ramp fwd");
      fill(32, 0);  run_block(32, 1'b1, 1'b0, "ramp inv");
      fill(0, 1);   run_block(0, 1'b0, 1'b0, "extreme fwd");
      fill(32, 1);  run_block(32, 1'b1, 1'b0, "extreme inv");
      fill(0, 2);   run_block(0, 1'b0, 1'b1, "busy start fwd");
      fill(32, 2);  run_block(32, 1'b1, 1'b1, "busy start inv");
      for (int t = 0; t < 4; t++) begin
         fill((t % 2) * 32, 2);
         run_block((t % 2) * 32, 1'(($urandom >> 3) & 1), 1'b0, "random");
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule